// File: doc/BRIEF.md
# Address-Decorated Atomic Read-Modify-Write Bridge

This bridge sits between one bus master (a processor core or a DMA engine) and two peripheral slave controllers. The master can ask for an operation by setting the upper address bits of an access into the peripheral window. The bridge removes that command from the address. It then runs either a plain access or an indivisible read-then-write sequence on the slave side. This lets software apply AND, OR, XOR and bit-field insert to a peripheral register with a single store, and read a bit field with a single load.

The master side uses a held request. The master keeps `m_req` and its fields steady until `m_ready` pulses, and then drops them. The slave side raises one of two request lines and holds it until that controller answers with ready. The answer carries the read data and an error flag. While a locked sequence runs, `s_lock` tells the slave fabric that nothing may be placed between the read and the write.

Top module: `decor_rmw_bridge`

## Requirements
- R1: An access is passed to the slave as a single unlocked access with its address unchanged when either of these holds: `m_decor_ok` is low, or address bits [31:29] are not 3'b010 (the window 0x4000_0000 to 0x5FFF_FFFF).
- R2: For a decorated access, the slave address is the master address with bits [28:20] cleared. The access goes to controller 1 (`s_req[1]`) when bit 19 of that stripped address is 1, and to controller 0 otherwise.
- R3: A decorated access with opcode 3'b000 in bits [28:26] is one plain access with the stripped address, whatever bits [25:20] hold. Opcodes 3'b101 to 3'b111 are reserved and are handled the same way.
- R4: A decorated write with opcode 3'b001 (AND), 3'b010 (OR) or 3'b011 (XOR) produces two slave accesses to the same address: a read, then a write of (old data OP write data). `s_lock` is high through both accesses, and no other slave access comes between them.
- R5: A decorated read with opcode AND, OR or XOR is a single plain read that returns the slave data.
- R6: A decorated write with opcode 3'b100 is a bit-field insert. It uses width = bits[25:23]+1 (1 to 8) and start = 8*addr[1:0] + bits[22:20]. The bridge reads the old word and writes back (old & ~M) | (wdata & M), where M is the mask of width ones starting at bit start. Any part of M above bit 31 is dropped.
- R7: A decorated read with opcode 3'b100 is a bit-field extract. It does a single slave read and returns (old & M) >> start, zero-extended. No write follows.
- R8: If the slave reports an error on the read phase of a locked sequence, the write phase is skipped and `m_err` is high with `m_ready`.
- R9: `m_ready` is high for exactly one cycle per request, and only after the last slave phase of that request has completed.
- R10: At most one bit of `s_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| m_req | input | 1 | Master request, held until m_ready |
| m_we | input | 1 | Master write (1) or read (0) |
| m_addr | input | 32 | Master address, possibly decorated |
| m_wdata | input | 32 | Master write data |
| m_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| m_decor_ok | input | 1 | Request comes from a core or DMA port that may decorate |
| m_ready | output | 1 | One-cycle completion pulse |
| m_rdata | output | 32 | Read result, valid with m_ready |
| m_err | output | 1 | Error result, valid with m_ready |
| s_req | output | 2 | Per-controller slave request |
| s_we | output | 1 | Slave write (1) or read (0) |
| s_addr | output | 32 | Stripped slave address |
| s_wdata | output | 32 | Slave write data |
| s_size | output | 2 | Slave access size |
| s_lock | output | 1 | High during both phases of a locked sequence |
| s_ready | input | 2 | Per-controller completion |
| s_rdata0 | input | 32 | Read data from controller 0 |
| s_rdata1 | input | 32 | Read data from controller 1 |
| s_err | input | 2 | Per-controller error, valid with s_ready |

## Verification
The bench covers six corner cases:
- A non-decorating source aimed at a decorated address. A bridge that ignored `m_decor_ok` would strip the address and send it to the wrong register.
- Opcode 000 with nonzero field bits, and a reserved opcode. Both must still give one plain access; a bridge that got this wrong would start a locked sequence or leave bits [25:20] in place.
- A bit-field insert whose field runs off the top of the word. A wrong mask would spill or wrap into low bits.
- An extract read. A bridge that wrote back would show a second slave access.
- A read-phase error. Continuing would corrupt the register with a write.
- Routing by bit 19. A wrong select would put data in the other controller's memory.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int DW = 32;
  localparam int AW = 32;
  localparam int POS_W = $clog2(DW);

  typedef enum logic [2:0] {
    OP_PLAIN = 3'b000,
    OP_AND   = 3'b001,
    OP_OR    = 3'b010,
    OP_XOR   = 3'b011,
    OP_BFI   = 3'b100
  } op_e;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_DONE} st_e;

  // Mask of (wm1+1) ones starting at bit pos, cut at the word top.
  function automatic logic [DW-1:0] field_mask(input logic [2:0] wm1,
                                               input logic [POS_W-1:0] pos);
    logic [DW+7:0] wide;
    wide = {{DW{1'b0}}, (8'hFF >> (3'd7 - wm1))} << pos;
    return wide[DW-1:0];
  endfunction

  function automatic logic [DW-1:0] merge_op(input op_e op,
                                             input logic [DW-1:0] old,
                                             input logic [DW-1:0] wd,
                                             input logic [DW-1:0] mask);
    case (op)
      OP_AND:  return old & wd;
      OP_OR:   return old | wd;
      OP_XOR:  return old ^ wd;
      OP_BFI:  return (old & ~mask) | (wd & mask);
      default: return wd;
    endcase
  endfunction

  function automatic logic [DW-1:0] pull_field(input logic [DW-1:0] old,
                                               input logic [DW-1:0] mask,
                                               input logic [POS_W-1:0] pos);
    return (old & mask) >> pos;
  endfunction
endpackage

// File: rtl/rmw_addr_decode.sv
module rmw_addr_decode
  import rmw_pkg::*;
#(
  parameter logic [2:0] WIN_TAG = 3'b010,
  parameter int         SEL_BIT = 19
) (
  input  logic [AW-1:0]    addr,
  input  logic             decor_ok,
  output logic             decorated,
  output op_e              op,
  output logic [AW-1:0]    phys,
  output logic             sel,
  output logic [DW-1:0]    mask,
  output logic [POS_W-1:0] pos
);
  localparam int LANE_W = POS_W - 3;

  logic [2:0] wm1;
  logic [2:0] lsb;

  assign decorated = decor_ok && (addr[31:29] == WIN_TAG);
  assign wm1       = addr[25:23];
  assign lsb       = addr[22:20];
  assign pos       = {addr[LANE_W-1:0], lsb};
  assign mask      = field_mask(wm1, pos);
  assign phys      = decorated ? {addr[31:29], 9'b0, addr[19:0]} : addr;
  assign sel       = phys[SEL_BIT];

  always_comb begin
    op = OP_PLAIN;
    if (decorated) begin
      case (addr[28:26])
        3'b001:  op = OP_AND;
        3'b010:  op = OP_OR;
        3'b011:  op = OP_XOR;
        3'b100:  op = OP_BFI;
        default: op = OP_PLAIN;
      endcase
    end
  end
endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
  import rmw_pkg::*;
(
  input  op_e              op,
  input  logic [DW-1:0]    old_data,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    mask,
  input  logic [POS_W-1:0] pos,
  output logic [DW-1:0]    new_data,
  output logic [DW-1:0]    field
);
  assign new_data = merge_op(op, old_data, wdata, mask);
  assign field    = pull_field(old_data, mask, pos);
endmodule

// File: rtl/rmw_sequencer.sv
module rmw_sequencer
  import rmw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             m_req,
  input  logic             m_we,
  input  logic [DW-1:0]    m_wdata,
  input  logic [1:0]       m_size,
  input  op_e              dec_op,
  input  logic [AW-1:0]    dec_phys,
  input  logic             dec_sel,
  input  logic [DW-1:0]    dec_mask,
  input  logic [POS_W-1:0] dec_pos,
  output logic             m_ready,
  output logic [DW-1:0]    m_rdata,
  output logic             m_err,
  output logic [1:0]       s_req,
  output logic             s_we,
  output logic [AW-1:0]    s_addr,
  output logic [DW-1:0]    s_wdata,
  output logic [1:0]       s_size,
  output logic             s_lock,
  input  logic             sel_ready,
  input  logic [DW-1:0]    sel_rdata,
  input  logic             sel_err,
  output op_e              cap_op,
  output logic [DW-1:0]    cap_wdata,
  output logic [DW-1:0]    cap_mask,
  output logic [POS_W-1:0] cap_pos,
  input  logic [DW-1:0]    alu_new,
  input  logic [DW-1:0]    alu_field
);
  st_e           state;
  logic          cap_sel, cap_wb, cap_xt;
  logic [AW-1:0] cap_addr;
  logic [1:0]    cap_size;
  logic [DW-1:0] wr_data, rsp_data;
  logic          rsp_err;
  logic          wb_now, phase_on, rd_done, wr_done;

  assign wb_now   = m_we && (dec_op != OP_PLAIN);
  assign phase_on = (state == ST_RD) || (state == ST_WR);
  assign rd_done  = (state == ST_RD) && sel_ready;
  assign wr_done  = (state == ST_WR) && sel_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cap_op    <= OP_PLAIN;
      cap_sel   <= 1'b0;
      cap_wb    <= 1'b0;
      cap_xt    <= 1'b0;
      cap_addr  <= '0;
      cap_size  <= '0;
      cap_wdata <= '0;
      cap_mask  <= '0;
      cap_pos   <= '0;
      wr_data   <= '0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (m_req) begin
          cap_op    <= dec_op;
          cap_sel   <= dec_sel;
          cap_wb    <= wb_now;
          cap_xt    <= !m_we && (dec_op == OP_BFI);
          cap_addr  <= dec_phys;
          cap_size  <= m_size;
          cap_wdata <= m_wdata;
          cap_mask  <= dec_mask;
          cap_pos   <= dec_pos;
          wr_data   <= m_wdata;
          rsp_data  <= '0;
          rsp_err   <= 1'b0;
          state     <= (m_we && !wb_now) ? ST_WR : ST_RD;
        end
        ST_RD: if (sel_ready) begin
          if (sel_err) begin
            rsp_err <= 1'b1;
            state   <= ST_DONE;
          end else if (cap_wb) begin
            wr_data <= alu_new;
            state   <= ST_WR;
          end else begin
            rsp_data <= cap_xt ? alu_field : sel_rdata;
            state    <= ST_DONE;
          end
        end
        ST_WR: if (sel_ready) begin
          rsp_err <= sel_err;
          state   <= ST_DONE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign m_ready = (state == ST_DONE);
  assign m_rdata = rsp_data;
  assign m_err   = rsp_err;
  assign s_req   = phase_on ? (cap_sel ? 2'b10 : 2'b01) : 2'b00;
  assign s_we    = (state == ST_WR);
  assign s_addr  = cap_addr;
  assign s_wdata = wr_data;
  assign s_size  = cap_size;
  assign s_lock  = cap_wb && phase_on;

  // R10
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_req));

  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && cap_wb && !sel_err) |=> (s_we && s_lock && (s_req != 2'b00) && $stable(s_addr)));

  // R8
  err_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && sel_err) |=> (s_req == 2'b00 && m_ready && m_err));

  // R7
  no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && !cap_wb) |=> (s_req == 2'b00 && m_ready));

  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_ready |=> !m_ready);

  // R9
  ready_after_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_ready) |-> ($past(rd_done) || $past(wr_done)));
endmodule

// File: rtl/decor_rmw_bridge.sv
module decor_rmw_bridge
  import rmw_pkg::*;
#(
  parameter logic [2:0] WIN_TAG = 3'b010,
  parameter int         SEL_BIT = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m_req,
  input  logic          m_we,
  input  logic [31:0]   m_addr,
  input  logic [31:0]   m_wdata,
  input  logic [1:0]    m_size,
  input  logic          m_decor_ok,
  output logic          m_ready,
  output logic [31:0]   m_rdata,
  output logic          m_err,
  output logic [1:0]    s_req,
  output logic          s_we,
  output logic [31:0]   s_addr,
  output logic [31:0]   s_wdata,
  output logic [1:0]    s_size,
  output logic          s_lock,
  input  logic [1:0]    s_ready,
  input  logic [31:0]   s_rdata0,
  input  logic [31:0]   s_rdata1,
  input  logic [1:0]    s_err
);
  logic             dec_decorated, dec_sel;
  op_e              dec_op, cap_op;
  logic [AW-1:0]    dec_phys;
  logic [DW-1:0]    dec_mask, cap_wdata, cap_mask, alu_new, alu_field, sel_rdata;
  logic [POS_W-1:0] dec_pos, cap_pos;
  logic             sel_ready, sel_err;

  // Route the answer of whichever controller owns the active request.
  assign sel_ready = |(s_ready & s_req);
  assign sel_err   = |(s_err & s_req);
  assign sel_rdata = s_req[1] ? s_rdata1 : s_rdata0;

  rmw_addr_decode #(.WIN_TAG(WIN_TAG), .SEL_BIT(SEL_BIT)) u_dec (
    .addr(m_addr), .decor_ok(m_decor_ok), .decorated(dec_decorated),
    .op(dec_op), .phys(dec_phys), .sel(dec_sel), .mask(dec_mask), .pos(dec_pos)
  );

  rmw_alu u_alu (
    .op(cap_op), .old_data(sel_rdata), .wdata(cap_wdata), .mask(cap_mask),
    .pos(cap_pos), .new_data(alu_new), .field(alu_field)
  );

  rmw_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_wdata(m_wdata),
    .m_size(m_size), .dec_op(dec_op), .dec_phys(dec_phys), .dec_sel(dec_sel),
    .dec_mask(dec_mask), .dec_pos(dec_pos), .m_ready(m_ready), .m_rdata(m_rdata),
    .m_err(m_err), .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_size(s_size), .s_lock(s_lock), .sel_ready(sel_ready), .sel_rdata(sel_rdata),
    .sel_err(sel_err), .cap_op(cap_op), .cap_wdata(cap_wdata), .cap_mask(cap_mask),
    .cap_pos(cap_pos), .alu_new(alu_new), .alu_field(alu_field)
  );

  // R1
  undecorated_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ready && s_req == 2'b00 && !dec_decorated) |=> (s_req == 2'b00 || s_addr == $past(m_addr)));
endmodule

// File: tb/decor_rmw_bridge_tb.sv
module decor_rmw_bridge_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        m_req = 0, m_we = 0, m_decor_ok = 0;
  logic [31:0] m_addr = 0, m_wdata = 0;
  logic [1:0]  m_size = 2'd2;
  logic        m_ready, m_err, s_we, s_lock;
  logic [31:0] m_rdata, s_addr, s_wdata, s_rdata0, s_rdata1;
  logic [1:0]  s_req, s_size, s_ready, s_err;

  decor_rmw_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_size(m_size), .m_decor_ok(m_decor_ok),
    .m_ready(m_ready), .m_rdata(m_rdata), .m_err(m_err), .s_req(s_req),
    .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_size(s_size),
    .s_lock(s_lock), .s_ready(s_ready), .s_rdata0(s_rdata0),
    .s_rdata1(s_rdata1), .s_err(s_err)
  );

  // Slave model: two word memories, one wait cycle, optional read error.
  logic [31:0] mem0 [16];
  logic [31:0] mem1 [16];
  logic [1:0]  rdy;
  logic        err_inj = 0;
  logic        log_we [64];
  logic        log_lock [64];
  logic        log_ctl [64];
  logic [31:0] log_addr [64];
  logic [31:0] log_data [64];
  int          log_n = 0;
  int          both_req = 0;
  int          checks = 0, fails = 0;

  assign s_ready  = rdy;
  assign s_rdata0 = mem0[s_addr[5:2]];
  assign s_rdata1 = mem1[s_addr[5:2]];
  assign s_err    = (err_inj && !s_we) ? rdy : 2'b00;

  always @(posedge clk) begin
    if (!rst_n) rdy <= 2'b00;
    else begin
      for (int i = 0; i < 2; i++) rdy[i] <= s_req[i] && !rdy[i];
      for (int i = 0; i < 2; i++) begin
        if (s_req[i] && rdy[i]) begin
          log_we[log_n[5:0]]   <= s_we;
          log_lock[log_n[5:0]] <= s_lock;
          log_ctl[log_n[5:0]]  <= (i == 1);
          log_addr[log_n[5:0]] <= s_addr;
          log_data[log_n[5:0]] <= s_we ? s_wdata : (i == 1 ? s_rdata1 : s_rdata0);
          log_n <= log_n + 1;
          if (s_we) begin
            if (i == 1) mem1[s_addr[5:2]] <= s_wdata;
            else mem0[s_addr[5:2]] <= s_wdata;
          end
        end
      end
    end
  end

  always @(negedge clk) if (rst_n && s_req == 2'b11) both_req++;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dec_addr(input int op, input int wm1,
      input int lsb, input int ctl, input int idx, input int lane);
    return 32'h4000_0000 | (32'(op) << 26) | (32'(wm1) << 23) | (32'(lsb) << 20)
         | (32'(ctl) << 19) | (32'(idx) << 2) | 32'(lane);
  endfunction

  function automatic logic [31:0] ref_mask(input int width, input int start);
    logic [31:0] m = '0;
    for (int b = 0; b < 32; b++) if (b >= start && b < start + width) m[b] = 1'b1;
    return m;
  endfunction

  logic [31:0] got_rdata;
  logic        got_err;
  int          base;

  task automatic access(input logic we, input logic [31:0] addr,
                        input logic [31:0] wd, input logic [1:0] sz, input logic src);
    @(negedge clk);
    base = log_n;
    m_req = 1; m_we = we; m_addr = addr; m_wdata = wd; m_size = sz; m_decor_ok = src;
    @(negedge clk);
    while (!m_ready) @(negedge clk);
    got_rdata = m_rdata;
    got_err   = m_err;
    m_req = 0;
    @(negedge clk);
    check(m_ready == 1'b0, "R9 ready one cycle", 32'(m_ready), 32'd0);
  endtask

  task automatic t_reset();
    check(m_ready == 0 && s_req == 0 && s_lock == 0, "R9 reset idle",
          {29'd0, m_ready, s_req}, 32'd0);
  endtask

  task automatic t_passthrough();
    access(1, 32'h2000_0010, 32'h1234_5678, 2, 1);
    check(log_n - base == 1 && log_addr[base] == 32'h2000_0010 && !log_lock[base],
          "R1 outside window", log_addr[base], 32'h2000_0010);
    access(0, 32'h4408_000C, 0, 2, 0);
    check(log_n - base == 1 && log_addr[base] == 32'h4408_000C && !log_we[base] && !log_lock[base],
          "R1 non-decorating source", log_addr[base], 32'h4408_000C);
  endtask

  task automatic t_plain();
    access(1, dec_addr(0, 6, 3, 0, 2, 0), 32'hCAFE_0001, 2, 1);
    check(log_n - base == 1 && log_addr[base] == 32'h4000_0008 && !log_ctl[base],
          "R3 plain write stripped", log_addr[base], 32'h4000_0008);
    check(mem0[2] == 32'hCAFE_0001, "R3 plain write data", mem0[2], 32'hCAFE_0001);
    access(0, dec_addr(5, 1, 1, 1, 1, 0), 0, 2, 1);
    check(log_n - base == 1 && log_addr[base] == 32'h4008_0004 && !log_lock[base],
          "R3 reserved opcode plain", log_addr[base], 32'h4008_0004);
    check(got_rdata == mem1[1], "R3 reserved read data", got_rdata, mem1[1]);
    check(log_ctl[base] == 1'b1, "R2 bit19 selects controller 1", 32'(log_ctl[base]), 32'd1);
  endtask

  task automatic t_logic_write(input int op, input logic [31:0] wd);
    logic [31:0] old = mem1[3];
    logic [31:0] exp;
    exp = (op == 1) ? (old & wd) : (op == 2) ? (old | wd) : (old ^ wd);
    access(1, dec_addr(op, 0, 0, 1, 3, 0), wd, 2, 1);
    check(log_n - base == 2 && !log_we[base] && log_we[base+1] && log_lock[base]
          && log_lock[base+1] && log_addr[base] == 32'h4008_000C
          && log_addr[base+1] == 32'h4008_000C, "R4 locked read then write",
          log_n - base, 32'd2);
    check(mem1[3] == exp, "R4 logical result", mem1[3], exp);
  endtask

  task automatic t_logic_read();
    access(0, dec_addr(2, 0, 0, 0, 5, 0), 32'hFFFF_FFFF, 2, 1);
    check(log_n - base == 1 && !log_we[base] && got_rdata == mem0[5],
          "R5 logic read is plain read", got_rdata, mem0[5]);
  endtask

  task automatic t_insert(input int wm1, input int lsb, input int lane,
                          input logic [31:0] wd, input string tag);
    logic [31:0] old = mem0[6];
    logic [31:0] m = ref_mask(wm1 + 1, lane * 8 + lsb);
    logic [31:0] exp = (old & ~m) | (wd & m);
    access(1, dec_addr(4, wm1, lsb, 0, 6, lane), wd, 0, 1);
    check(log_n - base == 2 && log_lock[base], {tag, " two phases"}, log_n - base, 32'd2);
    check(mem0[6] == exp, tag, mem0[6], exp);
  endtask

  task automatic t_extract();
    logic [31:0] old = mem1[7];
    logic [31:0] exp = (old & ref_mask(5, 8 + 3)) >> 11;
    access(0, dec_addr(4, 4, 3, 1, 7, 1), 0, 0, 1);
    check(got_rdata == exp, "R7 extract value", got_rdata, exp);
    check(log_n - base == 1 && !log_we[base] && mem1[7] == old,
          "R7 extract no write", log_n - base, 32'd1);
  endtask

  task automatic t_error();
    logic [31:0] old = mem0[9];
    err_inj = 1;
    access(1, dec_addr(3, 0, 0, 0, 9, 0), 32'hFFFF_0000, 2, 1);
    err_inj = 0;
    check(got_err == 1'b1, "R8 error returned", 32'(got_err), 32'd1);
    check(log_n - base == 1 && mem0[9] == old, "R8 write skipped", log_n - base, 32'd1);
  endtask

  logic finished = 0;

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem0[i] = 32'h1111_1111 * i ^ 32'hA5A5_0F0F;
      mem1[i] = 32'h0F0F_3C3C ^ (32'(i) << 8);
    end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_passthrough();
    t_plain();
    t_logic_write(1, 32'hF0F0_FF00);
    t_logic_write(2, 32'h0000_8001);
    t_logic_write(3, 32'hFFFF_0000);
    t_logic_read();
    t_insert(3, 2, 1, 32'hFFFF_FFFF, "R6 insert mid lane");
    t_insert(7, 0, 0, 32'h0000_005A, "R6 insert full byte");
    t_insert(7, 6, 3, 32'h4000_0000, "R6 insert cut at word top");
    t_extract();
    t_error();
    check(both_req == 0, "R10 one request at a time", both_req, 32'd0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule